// File: doc/BRIEF.md
# Fragment-Aware Translation Buffer

This block is a small, fully associative address translation cache. Each slot holds one page table entry, and that entry can describe a run of physically contiguous 4KB pages. A fragment code inside the entry sets the span to 2^(12+f) bytes. A lookup presents a virtual byte address and gets back, one cycle later, a hit flag, the physical byte address and the permission bits of the covering entry. A fill installs an entry for a given virtual address, and a flush input empties the whole buffer in one cycle.

Because one slot covers a whole fragment, a large contiguous mapping uses a single slot where 4KB paging would need many. The compare mask and the offset passthrough are chosen per slot from that slot's fragment code. A global enable can force every slot back to plain 4KB behaviour. Page walking, backing memory and further cache levels are left to the surrounding logic.

Top module: `frag_tlb`

## Requirements
- R1: After synchronous active-low reset, rsp_valid and rsp_hit are low and every slot is empty, so the first lookups miss.
- R2: A lookup presented in one cycle gives rsp_valid in the next cycle and at no other time. A miss returns rsp_paddr and rsp_perm as zero.
- R3: Entry layout: bit 0 is the valid bit, bits 6:1 are the permission bits, bits 10:7 are the fragment code, bit 11 is ignored, and bits 31:12 are the physical page number.
- R4: With frag_en high, an entry whose fragment code is f covers 2^(12+f) bytes, and codes above MAX_FRAG (8) act as 8. A lookup hits when its address agrees with the filled virtual address in every bit at or above 12+f.
- R5: On a hit, the physical address takes the bits at or above 12+f from the entry's page number and the bits below 12+f from the lookup address.
- R6: The permission bits of an entry are returned for every address within its fragment range.
- R7: With frag_en low at the lookup, every entry acts as 4KB. It matches only the exact page that was filled, and the physical address is the page number joined with lookup address bits 11:0.
- R8: There are 8 slots, filled in round-robin order starting at slot 0. The ninth fill replaces the first.
- R9: inval_all empties every slot at the next clock edge. A fill in the same cycle is dropped and does not move the round-robin pointer.
- R10: When several slots match a lookup, the lowest-numbered slot supplies the result.
- R11: A lookup in the same cycle as a fill or flush sees the contents from before that fill or flush.
- R12: A fill whose entry has the valid bit clear leaves its slot empty and still advances the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frag_en | input | 1 | Enables fragment sizes at lookup; low forces 4KB |
| lkp_valid | input | 1 | Lookup request |
| lkp_vaddr | input | 32 | Lookup virtual byte address |
| fill_valid | input | 1 | Fill request |
| fill_vaddr | input | 32 | Virtual byte address of the fill |
| fill_pte | input | 32 | Entry to install (layout in R3) |
| inval_all | input | 1 | Empty all slots |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Translated physical byte address |
| rsp_perm | output | 6 | Permission bits of the hit entry |

## Verification
The properties assume that rst_n is held low for at least one clock before traffic starts. They also assume that the response is judged against the lookup inputs of the cycle just before it, so lookup address and request must be stable across each sampling edge. The flush property relies on no fill being presented in the same cycle as the lookup that follows a flush, because a fill only becomes visible one edge later. The stimulus changes all inputs only on the falling edge and mixes fills, lookups and rare flushes freely. It aims lookup addresses near recently filled ones so that fragment boundaries, clamped codes and overlapping slots all come up.

// File: rtl/frag_tlb_pkg.sv
`timescale 1ns/1ps
// frag_tlb_pkg: entry layout constants shared by the translation buffer.
// Assumes 4KB base pages; field positions are decoded by the slot logic.
package frag_tlb_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int VALID_BIT  = 0;
    localparam int PERM_LSB   = 1;
    localparam int PERM_W     = 6;
    localparam int FRAG_LSB   = 7;
    localparam int FRAG_W     = 4;
endpackage

// File: rtl/frag_tlb_mask.sv
`timescale 1ns/1ps
// frag_tlb_mask: turns a fragment code into a mask of the address bits that
// take part in the tag compare (ones) versus the offset bits (zeros).
// Assumes MAX_FRAG + PAGE_SHIFT <= ADDR_W.
module frag_tlb_mask
    import frag_tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_FRAG = 8
) (
    input  logic [FRAG_W-1:0] code,
    input  logic              frag_en,
    output logic [ADDR_W-1:0] keep
);
    localparam int SHW = $clog2(ADDR_W + 1);

    logic [SHW-1:0] shift;

    // Select the page-size exponent: base page when disabled, clamp large codes.
    always_comb begin
        if (!frag_en)
            shift = SHW'(PAGE_SHIFT);
        else if (int'(code) > MAX_FRAG)
            shift = SHW'(PAGE_SHIFT + MAX_FRAG);
        else
            shift = SHW'(PAGE_SHIFT) + SHW'(code);
    end

    // Each bit at or above the exponent belongs to the compared tag.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign keep[b] = (SHW'(b) >= shift);
    end
endmodule

// File: rtl/frag_tlb_slot.sv
`timescale 1ns/1ps
// frag_tlb_slot: one buffer slot. Stores the filled virtual page and entry,
// and matches/translates a lookup using the mask for its own fragment code.
// Assumes clear has priority over a write in the same cycle.
module frag_tlb_slot
    import frag_tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int MAX_FRAG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_vaddr,
    input  logic [ADDR_W-1:0] wr_pte,
    input  logic              frag_en,
    input  logic [ADDR_W-1:0] lk_vaddr,
    output logic              match,
    output logic [ADDR_W-1:0] lk_paddr,
    output logic [PERM_W-1:0] lk_perm
);
    localparam int VP_W = ADDR_W - PAGE_SHIFT;

    logic              vld;
    logic [VP_W-1:0]   vpage;
    logic [VP_W-1:0]   ppage;
    logic [FRAG_W-1:0] code;
    logic [PERM_W-1:0] perm;
    logic [ADDR_W-1:0] keep;
    logic              unused_bits;

    assign unused_bits = ^{wr_pte[FRAG_LSB+FRAG_W], wr_vaddr[PAGE_SHIFT-1:0]};

    // Valid bit: cleared by flush, loaded from the entry's valid bit on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld <= 1'b0;
        else if (clear)
            vld <= 1'b0;
        else if (wr)
            vld <= wr_pte[VALID_BIT];
    end

    // Entry payload: captured on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpage <= '0;
            ppage <= '0;
            code  <= '0;
            perm  <= '0;
        end else if (wr && !clear) begin
            vpage <= wr_vaddr[ADDR_W-1:PAGE_SHIFT];
            ppage <= wr_pte[ADDR_W-1:PAGE_SHIFT];
            code  <= wr_pte[FRAG_LSB +: FRAG_W];
            perm  <= wr_pte[PERM_LSB +: PERM_W];
        end
    end

    frag_tlb_mask #(
        .ADDR_W  (ADDR_W),
        .MAX_FRAG(MAX_FRAG)
    ) u_mask (
        .code   (code),
        .frag_en(frag_en),
        .keep   (keep)
    );

    // Tag compare above the fragment size, base joined with passthrough offset.
    always_comb begin
        match    = vld && (((lk_vaddr[ADDR_W-1:PAGE_SHIFT] ^ vpage)
                             & keep[ADDR_W-1:PAGE_SHIFT]) == '0);
        lk_paddr = ({ppage, {PAGE_SHIFT{1'b0}}} & keep) | (lk_vaddr & ~keep);
        lk_perm  = perm;
    end
endmodule

// File: rtl/frag_tlb_pick.sv
`timescale 1ns/1ps
// frag_tlb_pick: priority select among matching slots, lowest index first.
// Outputs zero address and permissions when nothing matches.
module frag_tlb_pick
    import frag_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]             match,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] pa_in,
    input  logic [ENTRIES-1:0][PERM_W-1:0] perm_in,
    output logic                           hit,
    output logic [ADDR_W-1:0]              pa,
    output logic [PERM_W-1:0]              perm
);
    // Scan from the top so the lowest matching index is the last one taken.
    always_comb begin
        hit  = 1'b0;
        pa   = '0;
        perm = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit  = 1'b1;
                pa   = pa_in[i];
                perm = perm_in[i];
            end
        end
    end
endmodule

// File: rtl/frag_tlb.sv
`timescale 1ns/1ps
// frag_tlb: fully associative translation buffer with per-slot page size.
// Lookups answer one cycle later; fills go to a round-robin slot; a flush
// empties all slots and drops a fill in the same cycle.
// Assumes inputs are synchronous to clk.
module frag_tlb
    import frag_tlb_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ENTRIES  = 8,
    parameter int MAX_FRAG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frag_en,
    input  logic              lkp_valid,
    input  logic [ADDR_W-1:0] lkp_vaddr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_pte,
    input  logic              inval_all,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0]              ptr;
    logic                          fill_go;
    logic [ENTRIES-1:0]            match;
    logic [ENTRIES-1:0][ADDR_W-1:0] pa_all;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_all;
    logic                          sel_hit;
    logic [ADDR_W-1:0]             sel_pa;
    logic [PERM_W-1:0]             sel_perm;

    assign fill_go = fill_valid && !inval_all;

    // Round-robin victim pointer, advanced by each accepted fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (fill_go)
            ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        frag_tlb_slot #(
            .ADDR_W  (ADDR_W),
            .MAX_FRAG(MAX_FRAG)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (inval_all),
            .wr      (fill_go && (ptr == PTR_W'(i))),
            .wr_vaddr(fill_vaddr),
            .wr_pte  (fill_pte),
            .frag_en (frag_en),
            .lk_vaddr(lkp_vaddr),
            .match   (match[i]),
            .lk_paddr(pa_all[i]),
            .lk_perm (perm_all[i])
        );
    end

    frag_tlb_pick #(
        .ENTRIES(ENTRIES),
        .ADDR_W (ADDR_W)
    ) u_pick (
        .match  (match),
        .pa_in  (pa_all),
        .perm_in(perm_all),
        .hit    (sel_hit),
        .pa     (sel_pa),
        .perm   (sel_perm)
    );

    // Response register: one cycle after the lookup, zero payload on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lkp_valid;
            rsp_hit   <= lkp_valid && sel_hit;
            rsp_paddr <= (lkp_valid && sel_hit) ? sel_pa : '0;
            rsp_perm  <= (lkp_valid && sel_hit) ? sel_perm : '0;
        end
    end
endmodule

// File: rtl/frag_tlb_chk.sv
`timescale 1ns/1ps
// frag_tlb_chk: protocol and timing properties of the translation buffer,
// attached to every frag_tlb instance.
module frag_tlb_chk
    import frag_tlb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lkp_valid,
    input logic [ADDR_W-1:0] lkp_vaddr,
    input logic              fill_valid,
    input logic              inval_all,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [PERM_W-1:0] rsp_perm
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rsp_valid && !rsp_hit));

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_perm == '0));

    assert_hit_has_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    assert_offset_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PAGE_SHIFT-1:0] == $past(lkp_vaddr[PAGE_SHIFT-1:0])));

    assert_flush_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_all ##1 (lkp_valid && !fill_valid)) |=> !rsp_hit);
endmodule

bind frag_tlb frag_tlb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_vaddr (lkp_vaddr),
    .fill_valid(fill_valid),
    .inval_all (inval_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_perm  (rsp_perm)
);

// File: tb/sim_frag_tlb.sv
`timescale 1ns/1ps
// sim_frag_tlb: random plus directed bench with a reference model of the buffer.
module sim_frag_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frag_en = 1'b1;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_vaddr = '0;
    logic [31:0] fill_pte = '0;
    logic        inval_all = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_paddr;
    logic [5:0]  rsp_perm;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_va  [8];
    logic [31:0] m_pte [8];
    logic        m_vld [8];
    int          m_ptr = 0;

    always #2 clk = ~clk;

    frag_tlb u0 (
        .clk(clk), .rst_n(rst_n), .frag_en(frag_en),
        .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_pte(fill_pte),
        .inval_all(inval_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm)
    );

    function automatic logic [31:0] mkpte(input logic [19:0] pg, input logic [3:0] fr,
                                          input logic [5:0] pm, input logic v);
        return {pg, 1'b0, fr, pm, v};
    endfunction

    // Reference lookup from R3..R7 and R10.
    function automatic void ref_look(input logic [31:0] va, input logic en,
                                     output logic hit, output logic [31:0] pa,
                                     output logic [5:0] pm);
        hit = 1'b0; pa = '0; pm = '0;
        for (int i = 0; i < 8; i++) begin
            int f, s;
            logic [31:0] msk;
            f = int'(m_pte[i][10:7]);
            s = en ? 12 + ((f > 8) ? 8 : f) : 12;
            msk = 32'hFFFF_FFFF << s;
            if (!hit && m_vld[i] && (((va ^ m_va[i]) & msk) == 0)) begin
                hit = 1'b1;
                pa  = ({m_pte[i][31:12], 12'h000} & msk) | (va & ~msk);
                pm  = m_pte[i][6:1];
            end
        end
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge,
    // check the registered response at the next falling edge.
    task automatic step(input logic lv, input logic [31:0] lva, input logic fv,
                        input logic [31:0] fva, input logic [31:0] fpte,
                        input logic inv, input logic en, input string tag);
        logic eh; logic [31:0] ep; logic [5:0] em;
        lkp_valid = lv; lkp_vaddr = lva; fill_valid = fv; fill_vaddr = fva;
        fill_pte = fpte; inval_all = inv; frag_en = en;
        ref_look(lva, en, eh, ep, em);
        @(posedge clk);
        if (inv) begin
            for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
        end else if (fv) begin
            m_va[m_ptr] = fva; m_pte[m_ptr] = fpte; m_vld[m_ptr] = fpte[0];
            m_ptr = (m_ptr + 1) % 8;
        end
        @(negedge clk);
        lkp_valid = 1'b0; fill_valid = 1'b0; inval_all = 1'b0;
        check(rsp_valid == lv, {tag, " R2 valid"}, 64'(rsp_valid), 64'(lv));
        if (lv)
            check({rsp_hit, rsp_paddr, rsp_perm} == {eh, ep, em}, tag,
                  64'({rsp_hit, rsp_paddr, rsp_perm}), 64'({eh, ep, em}));
    endtask

    task automatic expect_pa(input logic [31:0] exp, input string tag);
        check(rsp_hit && rsp_paddr == exp, tag, 64'(rsp_paddr), 64'(exp));
    endtask

    task automatic look(input logic [31:0] va, input logic en, input string tag);
        step(1'b1, va, 1'b0, '0, '0, 1'b0, en, tag);
    endtask

    task automatic fill(input logic [31:0] va, input logic [31:0] pte, input string tag);
        step(1'b0, '0, 1'b1, va, pte, 1'b0, 1'b1, tag);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin m_va[i] = '0; m_pte[i] = '0; m_vld[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!rsp_valid && !rsp_hit, "R1 reset", 64'({rsp_valid, rsp_hit}), 64'(0));
        look(32'h0001_2345, 1'b1, "R1 empty");
        check(!rsp_hit, "R1 miss", 64'(rsp_hit), 64'(0));

        // R11: lookup in the fill cycle sees old contents
        step(1'b1, 32'h0001_2345, 1'b1, 32'h0001_2000, mkpte(20'hABCDE, 4'd0, 6'h2A, 1'b1),
             1'b0, 1'b1, "R11");
        look(32'h0001_2345, 1'b1, "R3");
        expect_pa(32'hABCD_E345, "R5 4KB");
        look(32'h0001_3345, 1'b1, "R4 4KB edge");
        fill(32'h0040_3000, mkpte(20'h12345, 4'd4, 6'h15, 1'b1), "R4 fill");
        look(32'h0040_F123, 1'b1, "R6");
        expect_pa(32'h1234_F123, "R5 64KB");
        look(32'h0041_0000, 1'b1, "R4 64KB edge");
        look(32'h0040_F123, 1'b0, "R7 off miss");
        look(32'h0040_3ABC, 1'b0, "R7 off hit");
        expect_pa(32'h1234_5ABC, "R7");
        fill(32'h0001_2000, mkpte(20'h55555, 4'd0, 6'h01, 1'b1), "R10 fill");
        look(32'h0001_2FFF, 1'b1, "R10");
        expect_pa(32'hABCD_EFFF, "R10 low slot");
        fill(32'h0080_0000, mkpte(20'h77712, 4'd15, 6'h3F, 1'b1), "R4 clamp fill");
        look(32'h008F_0001, 1'b1, "R4 clamp");
        expect_pa(32'h777F_0001, "R4 clamp pa");
        look(32'h0090_0000, 1'b1, "R4 clamp edge");
        fill(32'h00A0_0000, mkpte(20'h00AAA, 4'd0, 6'h07, 1'b0), "R12 fill");
        look(32'h00A0_0000, 1'b1, "R12");
        fill(32'h00B0_0000, mkpte(20'h00B00, 4'd0, 6'h01, 1'b1), "R8 fill5");
        fill(32'h00B1_0000, mkpte(20'h00B10, 4'd0, 6'h02, 1'b1), "R8 fill6");
        fill(32'h00B2_0000, mkpte(20'h00B20, 4'd0, 6'h03, 1'b1), "R8 fill7");
        fill(32'h00C0_0000, mkpte(20'h00C00, 4'd0, 6'h04, 1'b1), "R8 wrap");
        look(32'h0001_2345, 1'b1, "R8");
        expect_pa(32'h5555_5345, "R8 evicted");
        step(1'b1, 32'h0040_F123, 1'b1, 32'h00E0_0000, mkpte(20'h00E00, 4'd0, 6'h05, 1'b1),
             1'b1, 1'b1, "R9 R11 flush cycle");
        look(32'h00E0_0000, 1'b1, "R9 fill dropped");
        look(32'h0040_F123, 1'b1, "R9 flushed");
        check(!rsp_hit, "R9 miss", 64'(rsp_hit), 64'(0));
        fill(32'h00D0_0000, mkpte(20'h00D00, 4'd1, 6'h06, 1'b1), "R9 ptr");
        look(32'h00D0_1FFF, 1'b1, "R9 ptr kept");

        for (int k = 0; k < 3000; k++) begin
            logic [31:0] va, fva, pte;
            logic lv, fv, inv, en;
            int fsel;
            logic [3:0] codes [7];
            codes = '{4'd0, 4'd1, 4'd4, 4'd6, 4'd8, 4'd9, 4'd15};
            fsel = int'($urandom_range(0, 6));
            fva  = {10'h0, 2'($urandom), 20'($urandom)};
            pte  = {20'($urandom), 1'b0, codes[fsel], 6'($urandom), ($urandom_range(0, 9) != 0)};
            va   = ($urandom_range(0, 3) != 0) ? m_va[$urandom_range(0, 7)] : fva;
            va   = va ^ (32'($urandom) & (32'h000F_FFFF >> $urandom_range(0, 12)));
            lv   = ($urandom_range(0, 3) != 0);
            fv   = ($urandom_range(0, 2) == 0);
            inv  = ($urandom_range(0, 60) == 0);
            en   = ($urandom_range(0, 7) != 0);
            step(lv, va, fv, fva, pte, inv, en, "R4 R5 R6 R10 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule